// File: doc/BRIEF.md
# Serial Audio Frame Capture

This block receives a serial audio stream on three pins: a serial bit clock, a word-select line that marks frames, and a data line. The pins come from an external master and are oversampled by the faster system clock. A programmable transition of word-select starts each frame. The block numbers every sampled bit inside the frame and gathers one left and one right sample into 16-bit parallel words.

Software sets several things:
- the frame bit where each channel begins;
- a stop position, which fixes how many bits each channel takes;
- the bit order;
- the serial clock edge used for sampling;
- the word-select edge that opens a frame.

The captured bits always end up left-aligned in the 16-bit word, and the bits below the stop position are zero. Both words are presented together with a single-cycle valid strobe once the right channel is complete.

Top module: `audio_frame_rx`

## Requirements
- R1: While reset is asserted and after it is released, valid_o is 0 and left_o and right_o read 0 until the first capture completes.
- R2: With cfg_fall_edge_i = 0, ws_i and sd_i are taken on rising edges of sck_i. With cfg_fall_edge_i = 1, they are taken on falling edges.
- R3: With cfg_ws_rise_i = 0, a frame opens when the sampled ws_i goes from 1 to 0. With cfg_ws_rise_i = 1, it opens when ws_i goes from 0 to 1. The bit taken on that sample is frame bit 0, and each later sample adds one to the bit number. The opposite transition of ws_i does not restart the count.
- R4: With cfg_lsb_first_i = 0 (MSB first), frame bit start+k goes to word bit 15-k, for k from 0 up to 15-stop.
- R5: With cfg_lsb_first_i = 1 (LSB first), frame bit start+k goes to word bit stop+k, for k from 0 up to 15-stop.
- R6: Word bits below cfg_stop_i are always 0, so 16-stop bits are kept and sit left-aligned.
- R7: The left word uses cfg_left_start_i and the right word uses cfg_right_start_i. Frame bits outside both windows have no effect on either word.
- R8: valid_o is high for exactly one system clock per frame. It rises on the third system clock edge after the serial clock pin transition that carries right frame bit cfg_right_start_i + 15 - stop.
- R9: left_o and right_o change only together with valid_o and hold their values in between.
- R10: After reset, no sample is captured and valid_o stays 0 until a frame-opening transition of ws_i has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than sck_i |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | External serial bit clock |
| ws_i | input | 1 | External word-select / frame marker |
| sd_i | input | 1 | Serial data |
| cfg_left_start_i | input | 6 | Frame bit where the left sample begins |
| cfg_right_start_i | input | 6 | Frame bit where the right sample begins |
| cfg_stop_i | input | 4 | Lowest word bit written; bits below it read 0 |
| cfg_lsb_first_i | input | 1 | 0: MSB first, 1: LSB first |
| cfg_fall_edge_i | input | 1 | 0: sample on sck_i rising, 1: on falling |
| cfg_ws_rise_i | input | 1 | 0: ws_i falling opens a frame, 1: rising |
| left_o | output | 16 | Last completed left sample |
| right_o | output | 16 | Last completed right sample |
| valid_o | output | 1 | One-cycle strobe with each new left/right pair |

## Verification
A serial clock pin transition reaches the sampling logic after two synchronizer stages and one edge-compare stage. The output register then updates, so valid_o and the new words appear on the third system clock edge after the transition. The bench drives the pins just after a falling system clock edge and reads the outputs at each following falling edge. It records the bit number and the falling-edge index at which valid_o was seen, and expects exactly one strobe, at index 3 after the last right bit's sampling transition. It also checks that the words read at the end of the frame still equal the ones strobed.

// File: rtl/afr_pkg.sv
package afr_pkg;
  typedef enum logic {EDGE_RISE = 1'b0, EDGE_FALL = 1'b1} smp_edge_e;
  typedef enum logic {ORD_MSB = 1'b0, ORD_LSB = 1'b1} bit_order_e;
  localparam int SYNC_STAGES = 2;
  localparam int N_CHAN = 2;
endpackage

// File: rtl/afr_sync.sv
module afr_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) st_q[i] <= '0;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/afr_edge_det.sv
module afr_edge_det import afr_pkg::*; (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      sck_s_i,
  input  smp_edge_e sel_i,
  output logic      smp_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sck_s_i;
  end

  assign smp_o = (sel_i == EDGE_FALL) ? (prev_q & ~sck_s_i) : (~prev_q & sck_s_i);
endmodule

// File: rtl/afr_framer.sv
module afr_framer #(
  parameter int POS_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_i,
  input  logic             ws_i,
  input  logic             ws_rise_i,
  output logic             fstart_o,
  output logic             active_o,
  output logic [POS_W-1:0] idx_o
);
  logic             ws_prev_q, primed_q, in_frame_q;
  logic [POS_W-1:0] cnt_q;

  assign fstart_o = smp_i && primed_q &&
                    (ws_rise_i ? (!ws_prev_q && ws_i) : (ws_prev_q && !ws_i));
  assign active_o = fstart_o || (smp_i && in_frame_q);
  // saturate so an over-long frame cannot wrap into a channel window
  assign idx_o    = fstart_o ? '0 : ((&cnt_q) ? cnt_q : cnt_q + 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ws_prev_q  <= 1'b0;
      primed_q   <= 1'b0;
      in_frame_q <= 1'b0;
      cnt_q      <= '0;
    end else if (smp_i) begin
      ws_prev_q <= ws_i;
      primed_q  <= 1'b1;
      if (fstart_o) in_frame_q <= 1'b1;
      if (active_o) cnt_q <= idx_o;
    end
  end
endmodule

// File: rtl/afr_chan_cap.sv
module afr_chan_cap import afr_pkg::*; #(
  parameter int SAMPLE_W = 16,
  parameter int POS_W    = 6,
  localparam int STOP_W  = $clog2(SAMPLE_W),
  localparam int OW      = POS_W + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                smp_i,
  input  logic                fstart_i,
  input  logic                active_i,
  input  logic [POS_W-1:0]    idx_i,
  input  logic [POS_W-1:0]    start_i,
  input  logic [STOP_W-1:0]   stop_i,
  input  bit_order_e          order_i,
  input  logic                bit_i,
  output logic [SAMPLE_W-1:0] word_nxt_o,
  output logic                last_o
);
  logic [SAMPLE_W-1:0] work_q;
  logic [OW-1:0]       offs, n_bits;
  logic [STOP_W-1:0]   pos;
  logic                hit;

  always_comb begin
    offs   = {1'b0, idx_i} - {1'b0, start_i};
    n_bits = OW'(SAMPLE_W) - OW'(stop_i);
    hit    = smp_i && active_i && (idx_i >= start_i) && (offs < n_bits);
    pos    = (order_i == ORD_LSB) ? stop_i + offs[STOP_W-1:0]
                                  : STOP_W'(SAMPLE_W - 1) - offs[STOP_W-1:0];
    word_nxt_o = fstart_i ? '0 : work_q;
    if (hit) word_nxt_o[pos] = bit_i;
    last_o = hit && (offs == n_bits - 1'b1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    work_q <= '0;
    else if (smp_i) work_q <= word_nxt_o;
  end
endmodule

// File: rtl/audio_frame_rx.sv
module audio_frame_rx import afr_pkg::*; #(
  parameter int SAMPLE_W = 16,
  parameter int POS_W    = 6,
  localparam int STOP_W  = $clog2(SAMPLE_W)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sck_i,
  input  logic                ws_i,
  input  logic                sd_i,
  input  logic [POS_W-1:0]    cfg_left_start_i,
  input  logic [POS_W-1:0]    cfg_right_start_i,
  input  logic [STOP_W-1:0]   cfg_stop_i,
  input  logic                cfg_lsb_first_i,
  input  logic                cfg_fall_edge_i,
  input  logic                cfg_ws_rise_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o
);
  logic [2:0]          pins_s;
  logic                sck_s, ws_s, sd_s;
  logic                smp_edge, frame_start, frame_active;
  logic [POS_W-1:0]    bit_idx;
  logic [POS_W-1:0]    ch_start [N_CHAN];
  logic [SAMPLE_W-1:0] ch_word  [N_CHAN];
  logic                ch_last  [N_CHAN];

  afr_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sck_i, ws_i, sd_i}),
    .q_o   (pins_s)
  );
  assign {sck_s, ws_s, sd_s} = pins_s;

  afr_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sck_s_i(sck_s),
    .sel_i  (smp_edge_e'(cfg_fall_edge_i)),
    .smp_o  (smp_edge)
  );

  afr_framer #(.POS_W(POS_W)) u_framer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .smp_i    (smp_edge),
    .ws_i     (ws_s),
    .ws_rise_i(cfg_ws_rise_i),
    .fstart_o (frame_start),
    .active_o (frame_active),
    .idx_o    (bit_idx)
  );

  assign ch_start[0] = cfg_left_start_i;
  assign ch_start[1] = cfg_right_start_i;

  for (genvar c = 0; c < N_CHAN; c++) begin : g_ch
    afr_chan_cap #(.SAMPLE_W(SAMPLE_W), .POS_W(POS_W)) u_cap (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .smp_i     (smp_edge),
      .fstart_i  (frame_start),
      .active_i  (frame_active),
      .idx_i     (bit_idx),
      .start_i   (ch_start[c]),
      .stop_i    (cfg_stop_i),
      .order_i   (bit_order_e'(cfg_lsb_first_i)),
      .bit_i     (sd_s),
      .word_nxt_o(ch_word[c]),
      .last_o    (ch_last[c])
    );
  end

  // right channel completion publishes both words
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_o  <= '0;
      right_o <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= ch_last[1];
      if (ch_last[1]) begin
        left_o  <= ch_word[0];
        right_o <= ch_word[1];
      end
    end
  end
endmodule

// File: rtl/afr_checker.sv
module afr_checker #(
  parameter int SAMPLE_W = 16,
  parameter int STOP_W   = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                valid_o,
  input logic [SAMPLE_W-1:0] left_o,
  input logic [SAMPLE_W-1:0] right_o,
  input logic [STOP_W-1:0]   cfg_stop_i,
  input logic                smp_edge,
  input logic                frame_start
);
  logic [SAMPLE_W-1:0] low_mask;
  assign low_mask = (SAMPLE_W'(1) << cfg_stop_i) - SAMPLE_W'(1);

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R8
  AST_VALID_AFTER_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(smp_edge)); // R8
  AST_LEFT_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((left_o & low_mask) == '0)); // R6
  AST_RIGHT_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((right_o & low_mask) == '0)); // R6
  AST_WORDS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(left_o) && $stable(right_o))); // R9
  AST_START_ON_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start |-> smp_edge); // R3
  AST_SAMPLE_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_edge |=> !smp_edge); // R2
endmodule

bind audio_frame_rx afr_checker #(.SAMPLE_W(SAMPLE_W), .STOP_W(STOP_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_o    (valid_o),
  .left_o     (left_o),
  .right_o    (right_o),
  .cfg_stop_i (cfg_stop_i),
  .smp_edge   (smp_edge),
  .frame_start(frame_start)
);

// File: tb/audio_frame_rx_test.sv
module audio_frame_rx_test;
  localparam int POS_W = 6;
  localparam int FRAME = 64;
  localparam int HALF  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, ws = 1'b0, sd = 1'b0;
  logic [POS_W-1:0] lstart = '0, rstart = '0;
  logic [3:0] stop = '0;
  logic lsb = 1'b0, fall = 1'b0, wsr = 1'b0;
  logic [15:0] left, right;
  logic valid;

  always #5 clk = ~clk;

  audio_frame_rx uut (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .ws_i(ws), .sd_i(sd),
    .cfg_left_start_i(lstart), .cfg_right_start_i(rstart), .cfg_stop_i(stop),
    .cfg_lsb_first_i(lsb), .cfg_fall_edge_i(fall), .cfg_ws_rise_i(wsr),
    .left_o(left), .right_o(right), .valid_o(valid)
  );

  int n_chk = 0, n_fail = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;
  logic data [FRAME];
  int v_seen, v_bit, v_phase, cur_bit;
  logic [15:0] v_left, v_right;

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expect_word(input int st, input int sp, input bit lsbf);
    logic [15:0] w = '0;
    for (int k = 0; k < 16 - sp; k++) begin
      if (lsbf) w[sp + k] = data[st + k];
      else      w[15 - k] = data[st + k];
    end
    return w;
  endfunction

  task automatic watch_half(input int sample_half);
    for (int p = 1; p <= HALF; p++) begin
      @(negedge clk);
      if (valid) begin
        v_seen++;
        v_bit   = cur_bit;
        v_phase = sample_half ? p : 100 + p;
        v_left  = left;
        v_right = right;
      end
    end
  endtask

  task automatic send_bit(input logic w, input logic d, input int bi);
    cur_bit = bi;
    sck = fall;  // launch level
    ws  = w;
    sd  = d;
    watch_half(0);
    sck = ~fall; // sampling transition
    watch_half(1);
  endtask

  task automatic run_config(input int ls, input int rs, input int sp, input bit lb, input bit fe, input bit wr);
    logic [15:0] el, er;
    int n;
    string otag;
    lstart = POS_W'(ls); rstart = POS_W'(rs); stop = 4'(sp);
    lsb = lb; fall = fe; wsr = wr;
    sck = fe; ws = ~wr; sd = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!valid && left == 0 && right == 0, "R1 reset state", {left[14:0], valid}, 16'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // idle bits with ws parked at the non-start level
    v_seen = 0;
    for (int b = 0; b < 3; b++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      send_bit(~wr, lfsr[0], -1);
    end
    check(v_seen == 0, "R10 no valid before frame start", 16'(v_seen), 16'h0);
    check(left == 0 && right == 0, "R1 words zero after reset", left | right, 16'h0);
    n = 16 - sp;
    otag = lb ? "R5" : "R4";
    for (int f = 0; f < 2; f++) begin
      for (int b = 0; b < FRAME; b++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        data[b] = lfsr[3];
      end
      el = expect_word(ls, sp, lb);
      er = expect_word(rs, sp, lb);
      v_seen = 0; v_bit = -1; v_phase = -1;
      for (int b = 0; b < FRAME; b++)
        send_bit((b < FRAME / 2) ? wr : ~wr, data[b], b);
      check(v_seen == 1, "R8 one valid per frame", 16'(v_seen), 16'h1);
      check(v_bit == rs + n - 1, "R3 R8 valid on last right bit", 16'(v_bit), 16'(rs + n - 1));
      check(v_phase == 3, "R8 valid three clocks after sck edge", 16'(v_phase), 16'h3);
      check(v_left == el, $sformatf("%s R2 R3 R6 left ls=%0d sp=%0d fe=%0d wr=%0d", otag, ls, sp, fe, wr), v_left, el);
      check(v_right == er, $sformatf("%s R7 R6 right rs=%0d sp=%0d fe=%0d wr=%0d", otag, rs, sp, fe, wr), v_right, er);
      check(left == v_left && right == v_right, "R9 words held after strobe", left ^ right, v_left ^ v_right);
    end
  endtask

  initial begin
    int lss [3] = '{0, 5, 1};
    int rss [3] = '{32, 40, 17};
    int sps [4] = '{0, 4, 8, 15};
    for (int lb = 0; lb < 2; lb++)
      for (int fe = 0; fe < 2; fe++)
        for (int wr = 0; wr < 2; wr++)
          for (int s = 0; s < 4; s++)
            for (int p = 0; p < 3; p++)
              run_config(lss[p], rss[p], sps[s], lb[0], fe[0], wr[0]);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(1_950_000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule